// File: doc/BRIEF.md
# Synchronizer Mode Control State Machine

This block decides how a telecom clock synchronizer runs at any moment. It chooses one of seven states, and each state fixes two things: the loop behaviour of the DPLL (free running, locked, holding its last frequency, or holding because its input went bad) and which of the two reference inputs feeds it. The block also raises a one-frame strobe for the phase-step corrector on every transition that needs one. A registered copy of the primary loss-of-signal input is fed back out so that an external RC network can build a guard-time delay.

Two control methods are available. Under manual control, a two-bit mode word picks normal, holdover or freerun operation, and a reference-select pin picks the source. Under automatic control, the two loss-of-signal inputs and the guard input drive the sequence. The block acts on its inputs only in a clock cycle where the frame strobe is high. That strobe marks the rising edge of the 8 kHz frame pulse, and every state change happens then.

The states are FREE (freerun), NORM_P and NORM_S (normal on the primary or secondary reference), HOLD_P and HOLD_S (holdover tied to a reference), and AHOLD_P and AHOLD_S (auto-holdover after the reference was reported invalid). The transitions are named in the requirements below. "Corrected" means the corrector strobe fires on that transition.

Top module: `sync_mode_fsm`

## Requirements
- R1: An asynchronous active-low reset sets the state to FREE, drives dpll_mode and sel_sec to 0, and clears tie_en and guard_out.
- R2: dpll_mode reads 00 in FREE, 01 in either NORM state, 10 in either HOLD state and 11 in either AHOLD state. sel_sec is 1 exactly in NORM_S, HOLD_S and AHOLD_S.
- R3: In a cycle without frm_stb, every output keeps its value, whatever the other inputs do.
- R4: mode_sel = 10 moves any state to FREE without a strobe (force-freerun).
- R5: mode_sel = 00 is manual normal, with ref_sel r (0 primary, 1 secondary) naming the target NORM state. With ref_bad = 0, every state goes to NORM_r. With ref_bad = 1, NORM_r goes to AHOLD_r (lose-ref) and every other state stays where it is.
- R6: mode_sel = 01 is manual holdover. NORM_r and AHOLD_r go to HOLD_r (enter-holdover). Every other state stays where it is.
- R7: In manual normal, these transitions are corrected: any change of reference, and HOLD_r to NORM_r only when guard_in = 1. FREE to NORM_r is not corrected.
- R8: AHOLD_r returns to NORM_r once ref_bad = 0, and the return is not corrected (auto-recover). The only exception is a manual change to the other reference, which is corrected.
- R9: When mode_sel = 11 with ref_sel = 0 is first seen (auto-entry), the state becomes NORM_P if los_pri = 0 and HOLD_P otherwise. The entry is corrected only when it moves from a secondary state to NORM_P. With mode_sel = 11 and ref_sel = 1 (reserved), the state does not change.
- R10: Under automatic control in NORM_P, los_pri = 1 leads to NORM_S (corrected) when guard_in = 1 and los_sec = 0, and to HOLD_P otherwise. With los_pri = 0 and ref_bad = 1, the state goes to AHOLD_P.
- R11: Under automatic control:
  - HOLD_P goes to NORM_P when los_pri = 0, corrected only if guard_in = 1. Otherwise it goes to NORM_S (corrected) when guard_in = 1 and los_sec = 0.
  - NORM_S and HOLD_S go to NORM_P (corrected) when los_pri = 0.
  - Otherwise NORM_S goes to HOLD_S on los_sec = 1, or to AHOLD_S on ref_bad = 1.
  - Otherwise HOLD_S goes to NORM_S on los_sec = 0, corrected only if guard_in = 1.
- R12: tie_en rises on the frame edge of a corrected transition, stays high until the next frame edge, and is high only while dpll_mode = 01.
- R13: guard_out takes the value of los_pri at each frame edge and holds it in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_stb | input | 1 | One-cycle strobe at the rising frame-pulse edge |
| mode_sel | input | 2 | 00 manual normal, 01 manual holdover, 10 freerun, 11 automatic |
| ref_sel | input | 1 | Manual reference choice (0 primary, 1 secondary); must be 0 under automatic control |
| guard_in | input | 1 | Guard-time input |
| los_pri | input | 1 | Primary loss of signal |
| los_sec | input | 1 | Secondary loss of signal |
| ref_bad | input | 1 | Impairment flag for the selected reference |
| sel_sec | output | 1 | Reference mux select, 1 = secondary |
| dpll_mode | output | 2 | DPLL mode code, encoded as in R2 |
| tie_en | output | 1 | Phase-corrector enable strobe |
| guard_out | output | 1 | los_pri registered at the frame edge |

## Verification
The assertions take for granted that the inputs are already synchronous to clk, and that frm_stb is a clean pulse lasting a single cycle per frame. They also take the output codes of R2 as the only way the state is visible. The stimulus changes inputs only on the falling clock edge and drives frm_stb for exactly one cycle. Between frames it inverts every control input for one idle cycle, so the hold-off of R3 is exercised against real input activity. The sweep visits every combination of mode, reference select, guard and validity inputs, including the reserved automatic setting, from whatever state the previous frames left.

// File: rtl/sms_pkg.sv
package sms_pkg;

    typedef enum logic [2:0] {
        ST_FREE    = 3'd0,
        ST_NORM_P  = 3'd1,
        ST_NORM_S  = 3'd2,
        ST_HOLD_P  = 3'd3,
        ST_HOLD_S  = 3'd4,
        ST_AHOLD_P = 3'd5,
        ST_AHOLD_S = 3'd6
    } sms_state_e;

    typedef enum logic [1:0] {
        CTL_NORM = 2'b00,
        CTL_HOLD = 2'b01,
        CTL_FREE = 2'b10,
        CTL_AUTO = 2'b11
    } sms_ctl_e;

    typedef enum logic [1:0] {
        DM_FREE  = 2'b00,
        DM_NORM  = 2'b01,
        DM_HOLD  = 2'b10,
        DM_AHOLD = 2'b11
    } sms_dmode_e;

    function automatic sms_state_e st_norm(input logic r);
        return r ? ST_NORM_S : ST_NORM_P;
    endfunction

    function automatic sms_state_e st_hold(input logic r);
        return r ? ST_HOLD_S : ST_HOLD_P;
    endfunction

    function automatic sms_state_e st_ahold(input logic r);
        return r ? ST_AHOLD_S : ST_AHOLD_P;
    endfunction

    function automatic logic st_ref(input sms_state_e s);
        return (s == ST_NORM_S) || (s == ST_HOLD_S) || (s == ST_AHOLD_S);
    endfunction

endpackage

// File: rtl/sms_manual_next.sv
module sms_manual_next
    import sms_pkg::*;
(
    input  sms_state_e cur,
    input  logic       hold_req,
    input  logic       ref_sel,
    input  logic       guard_in,
    input  logic       ref_bad,
    output sms_state_e nxt,
    output logic       corr
);

    always_comb begin
        nxt  = cur;
        corr = 1'b0;
        if (hold_req) begin
            // enter-holdover only from the same reference's normal states
            if (cur == st_norm(ref_sel) || cur == st_ahold(ref_sel))
                nxt = st_hold(ref_sel);
        end else if (ref_bad) begin
            // lose-ref: a normal state falls into auto-holdover
            if (cur == st_norm(ref_sel))
                nxt = st_ahold(ref_sel);
        end else begin
            nxt = st_norm(ref_sel);
            if (cur == ST_FREE || cur == st_norm(ref_sel) || cur == st_ahold(ref_sel))
                corr = 1'b0;
            else if (cur == st_hold(ref_sel))
                corr = guard_in;
            else
                corr = 1'b1;
        end
    end

endmodule

// File: rtl/sms_auto_next.sv
module sms_auto_next
    import sms_pkg::*;
(
    input  sms_state_e cur,
    input  logic       auto_q,
    input  logic       ref_sel,
    input  logic       guard_in,
    input  logic       los_pri,
    input  logic       los_sec,
    input  logic       ref_bad,
    output sms_state_e nxt,
    output logic       corr
);

    always_comb begin
        nxt  = cur;
        corr = 1'b0;
        if (ref_sel) begin
            nxt = cur;                       // reserved setting: hold
        end else if (!auto_q) begin
            nxt  = los_pri ? ST_HOLD_P : ST_NORM_P;
            corr = !los_pri && st_ref(cur);
        end else begin
            unique case (cur)
                ST_NORM_P: begin
                    if (los_pri) begin
                        if (guard_in && !los_sec) begin
                            nxt  = ST_NORM_S;
                            corr = 1'b1;
                        end else begin
                            nxt = ST_HOLD_P;
                        end
                    end else if (ref_bad) begin
                        nxt = ST_AHOLD_P;
                    end
                end
                ST_HOLD_P: begin
                    if (!los_pri) begin
                        nxt  = ST_NORM_P;
                        corr = guard_in;
                    end else if (guard_in && !los_sec) begin
                        nxt  = ST_NORM_S;
                        corr = 1'b1;
                    end
                end
                ST_NORM_S: begin
                    if (!los_pri) begin
                        nxt  = ST_NORM_P;
                        corr = 1'b1;
                    end else if (los_sec) begin
                        nxt = ST_HOLD_S;
                    end else if (ref_bad) begin
                        nxt = ST_AHOLD_S;
                    end
                end
                ST_HOLD_S: begin
                    if (!los_pri) begin
                        nxt  = ST_NORM_P;
                        corr = 1'b1;
                    end else if (!los_sec) begin
                        nxt  = ST_NORM_S;
                        corr = guard_in;
                    end
                end
                ST_AHOLD_P: if (!ref_bad) nxt = ST_NORM_P;
                ST_AHOLD_S: if (!ref_bad) nxt = ST_NORM_S;
                default:    nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm
    import sms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_stb,
    input  logic [1:0] mode_sel,
    input  logic       ref_sel,
    input  logic       guard_in,
    input  logic       los_pri,
    input  logic       los_sec,
    input  logic       ref_bad,
    output logic       sel_sec,
    output logic [1:0] dpll_mode,
    output logic       tie_en,
    output logic       guard_out
);

    sms_ctl_e   ctl;
    sms_state_e state_q, nxt_state;
    sms_state_e man_nxt, auto_nxt;
    logic       man_corr, auto_corr, nxt_corr;
    logic       auto_q, nxt_auto;
    logic       tie_q, gto_q;
    sms_dmode_e dm;

    assign ctl = sms_ctl_e'(mode_sel);

    sms_manual_next u_man (
        .cur      (state_q),
        .hold_req (ctl == CTL_HOLD),
        .ref_sel  (ref_sel),
        .guard_in (guard_in),
        .ref_bad  (ref_bad),
        .nxt      (man_nxt),
        .corr     (man_corr)
    );

    sms_auto_next u_auto (
        .cur      (state_q),
        .auto_q   (auto_q),
        .ref_sel  (ref_sel),
        .guard_in (guard_in),
        .los_pri  (los_pri),
        .los_sec  (los_sec),
        .ref_bad  (ref_bad),
        .nxt      (auto_nxt),
        .corr     (auto_corr)
    );

    always_comb begin
        unique case (ctl)
            CTL_FREE: begin
                nxt_state = ST_FREE;
                nxt_corr  = 1'b0;
            end
            CTL_AUTO: begin
                nxt_state = auto_nxt;
                nxt_corr  = auto_corr;
            end
            default: begin
                nxt_state = man_nxt;
                nxt_corr  = man_corr;
            end
        endcase
        if (ctl != CTL_AUTO)
            nxt_auto = 1'b0;
        else if (!ref_sel)
            nxt_auto = 1'b1;
        else
            nxt_auto = auto_q;
    end

    // state register: every update waits for the frame strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            auto_q  <= 1'b0;
            tie_q   <= 1'b0;
            gto_q   <= 1'b0;
        end else if (frm_stb) begin
            state_q <= nxt_state;
            auto_q  <= nxt_auto;
            tie_q   <= nxt_corr;
            gto_q   <= los_pri;
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_NORM_P, ST_NORM_S:   dm = DM_NORM;
            ST_HOLD_P, ST_HOLD_S:   dm = DM_HOLD;
            ST_AHOLD_P, ST_AHOLD_S: dm = DM_AHOLD;
            default:                dm = DM_FREE;
        endcase
        sel_sec   = st_ref(state_q);
        dpll_mode = dm;
        tie_en    = tie_q;
        guard_out = gto_q;
    end

endmodule

// File: rtl/sms_chk.sv
module sms_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_stb,
    input logic [1:0] mode_sel,
    input logic       ref_sel,
    input logic       ref_bad,
    input logic       los_pri,
    input logic       sel_sec,
    input logic [1:0] dpll_mode,
    input logic       tie_en,
    input logic       guard_out
);

    a_r3_quiet_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_stb |=> $stable(dpll_mode) && $stable(sel_sec) && $stable(tie_en) && $stable(guard_out));

    a_r4_force_freerun: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && mode_sel == 2'b10 |=> dpll_mode == 2'b00 && !tie_en && !sel_sec);

    a_r6_enter_holdover: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && mode_sel == 2'b01 && dpll_mode == 2'b01 && ref_sel == sel_sec
        |=> dpll_mode == 2'b10 && sel_sec == $past(sel_sec));

    a_r8_recover_uncorrected: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb && mode_sel == 2'b00 && dpll_mode == 2'b11 && !ref_bad && ref_sel == sel_sec
        |=> dpll_mode == 2'b01 && !tie_en && sel_sec == $past(sel_sec));

    a_r12_strobe_in_normal: assert property (@(posedge clk) disable iff (!rst_n)
        tie_en |-> dpll_mode == 2'b01);

    a_r12_strobe_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tie_en) |-> $past(frm_stb));

    a_r13_guard_copy: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb |=> guard_out == $past(los_pri));

endmodule

bind sync_mode_fsm sms_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_stb   (frm_stb),
    .mode_sel  (mode_sel),
    .ref_sel   (ref_sel),
    .ref_bad   (ref_bad),
    .los_pri   (los_pri),
    .sel_sec   (sel_sec),
    .dpll_mode (dpll_mode),
    .tie_en    (tie_en),
    .guard_out (guard_out)
);

// File: tb/sim_sync_mode_fsm.sv
module sim_sync_mode_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_stb = 1'b0;
    logic [1:0] mode_sel = 2'b10;
    logic       ref_sel = 1'b0, guard_in = 1'b0, los_pri = 1'b0, los_sec = 1'b0, ref_bad = 1'b0;
    logic       sel_sec, tie_en, guard_out;
    logic [1:0] dpll_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of state: 0 FREE,1 NORM_P,2 NORM_S,3 HOLD_P,4 HOLD_S,5 AHOLD_P,6 AHOLD_S
    int m_st = 0;
    bit m_auto = 0, m_tie = 0, m_guard = 0;

    always #4 clk = ~clk;

    sync_mode_fsm u0 (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .mode_sel(mode_sel),
        .ref_sel(ref_sel), .guard_in(guard_in), .los_pri(los_pri), .los_sec(los_sec),
        .ref_bad(ref_bad), .sel_sec(sel_sec), .dpll_mode(dpll_mode), .tie_en(tie_en),
        .guard_out(guard_out)
    );

    function automatic bit is_sec(int s);
        return s == 2 || s == 4 || s == 6;
    endfunction

    function automatic int exp_dm(int s);
        if (s == 0) return 0;
        return (s + 1) / 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit [1:0] md, input bit rs, g, lp, ls, bad);
        int n = m_st;
        bit c = 0;
        int r = rs;
        case (md)
            2'b10: n = 0;
            2'b11: begin
                if (rs) n = m_st;
                else if (!m_auto) begin
                    n = lp ? 3 : 1;
                    c = !lp && is_sec(m_st);
                end else begin
                    case (m_st)
                        1: if (lp) begin if (g && !ls) begin n = 2; c = 1; end else n = 3; end
                           else if (bad) n = 5;
                        3: if (!lp) begin n = 1; c = g; end
                           else if (g && !ls) begin n = 2; c = 1; end
                        2: if (!lp) begin n = 1; c = 1; end
                           else if (ls) n = 4;
                           else if (bad) n = 6;
                        4: if (!lp) begin n = 1; c = 1; end
                           else if (!ls) begin n = 2; c = g; end
                        5: if (!bad) n = 1;
                        6: if (!bad) n = 2;
                        default: n = m_st;
                    endcase
                end
            end
            2'b01: if (m_st == 1 + r || m_st == 5 + r) n = 3 + r;
            default: begin
                if (bad) begin
                    if (m_st == 1 + r) n = 5 + r;
                end else begin
                    n = 1 + r;
                    if (m_st == 0 || m_st == 1 + r || m_st == 5 + r) c = 0;
                    else if (m_st == 3 + r) c = g;
                    else c = 1;
                end
            end
        endcase
        if (md != 2'b11) m_auto = 0;
        else if (!rs) m_auto = 1;
        m_st = n;
        m_tie = c;
        m_guard = lp;
    endtask

    task automatic check_outputs(input string tag);
        chk(dpll_mode == 2'(exp_dm(m_st)), {tag, " dpll_mode"}, dpll_mode, exp_dm(m_st));
        chk(sel_sec == is_sec(m_st), {tag, " sel_sec"}, sel_sec, is_sec(m_st));
        chk(tie_en == m_tie, {tag, " tie_en"}, tie_en, m_tie);
        chk(guard_out == m_guard, "R13 guard_out", guard_out, m_guard);
    endtask

    // one frame: drive on falling edge, strobe one cycle, sample at next falling edge,
    // then an idle cycle with every input inverted to show nothing moves (R3)
    task automatic frame(input bit [1:0] md, input bit rs, g, lp, ls, bad, input string tag);
        @(negedge clk);
        mode_sel = md; ref_sel = rs; guard_in = g; los_pri = lp; los_sec = ls; ref_bad = bad;
        frm_stb = 1'b1;
        model_step(md, rs, g, lp, ls, bad);
        @(negedge clk);
        frm_stb = 1'b0;
        check_outputs(tag);
        mode_sel = ~md; ref_sel = ~rs; guard_in = ~g; los_pri = ~lp; los_sec = ~ls; ref_bad = ~bad;
        @(negedge clk);
        check_outputs("R3 idle");
    endtask

    function automatic string sweep_tag(bit [1:0] md, bit rs);
        if (md == 2'b10) return "R4";
        if (md == 2'b00) return "R5";
        if (md == 2'b01) return "R6";
        if (rs || !m_auto) return "R9";
        if (m_st == 1) return "R10";
        return "R11";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_outputs("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 after release");

        // directed walk
        frame(2'b00, 0, 0, 0, 0, 0, "R2 freerun->NORM_P");
        frame(2'b00, 1, 0, 0, 0, 0, "R7 ref change corrected");
        frame(2'b00, 1, 0, 0, 0, 0, "R12 strobe one frame");
        frame(2'b01, 1, 0, 0, 0, 0, "R6 enter HOLD_S");
        frame(2'b00, 1, 0, 0, 0, 0, "R7 hold return guard 0");
        frame(2'b01, 1, 0, 0, 0, 0, "R6 enter HOLD_S again");
        frame(2'b00, 1, 1, 0, 0, 0, "R7 hold return guard 1");
        frame(2'b00, 1, 0, 1, 0, 1, "R8 lose-ref AHOLD_S");
        frame(2'b00, 1, 0, 1, 0, 0, "R8 auto-recover");
        frame(2'b10, 1, 1, 1, 1, 1, "R4 force freerun");
        frame(2'b11, 1, 0, 0, 0, 0, "R9 reserved holds");
        frame(2'b11, 0, 0, 0, 0, 0, "R9 auto-entry");
        frame(2'b11, 0, 1, 1, 0, 0, "R10 switch to NORM_S");
        frame(2'b11, 0, 0, 0, 0, 0, "R11 revert NORM_P");
        frame(2'b11, 0, 0, 1, 0, 0, "R10 fall to HOLD_P");
        frame(2'b11, 0, 1, 0, 0, 0, "R11 HOLD_P recover");
        frame(2'b11, 0, 0, 0, 0, 1, "R10 lose-ref AHOLD_P");

        // near-exhaustive sweep over every input combination from evolving states
        for (int rnd = 0; rnd < 40; rnd++) begin
            for (int v = 0; v < 128; v++) begin
                bit [6:0] p = 7'((v * 37 + rnd * 11) & 127);
                frame(p[1:0], p[2], p[3], p[4], p[5], p[6], sweep_tag(p[1:0], p[2]));
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule